// File: doc/BRIEF.md
# CAN Receive Acceptance Mask Filter

This block decides which receive slots accept an incoming CAN frame. It keeps three 32-bit acceptance masks: one global mask and two legacy masks, each tied to one buffer. For every entry of an 8-entry receive FIFO filter table, and for every one of 16 receive message buffers, it picks the mask that applies. It then compares the received identifier, IDE and RTR bits against that entry's programmed values under that mask. The filter table contents and the buffer identifiers arrive as flat input buses from the surrounding controller. This block only stores the masks and does the matching.

Masks are loaded through a small register port, and a load takes effect only while the freeze input is high. A strobed frame produces registered hit vectors for the FIFO table and for the buffers one clock later. Along with them come a flag saying whether any FIFO entry matched and the index of the lowest-numbered matching FIFO entry. Two mode inputs steer mask selection. One enables FIFO mode. The other is a compatibility switch that retires both legacy masks in favour of the global one.

Top module: `can_mask_filter`

## Requirements
- R1: After synchronous reset all three masks read back as 32'hFFFF_FFFF, and hit_valid_o, fifo_hit_o, fifo_any_o, fifo_win_o and mb_hit_o are zero.
- R2: A compared bit position whose mask bit is 1 must hold the same value in the frame and in the entry. Where the mask bit is 0, the position is ignored. The mask bit layout is: bits 28..0 cover identifier bits 28..0, bit 29 covers IDE and bit 30 covers RTR.
- R3: A mask is loaded from reg_wdata_i on a clock edge where reg_wr_i and freeze_i are both high. Any write while freeze_i is low leaves every mask unchanged.
- R4: FIFO entries 0 to 5 always use the global mask. Entry 6 uses the legacy-14 mask and entry 7 the legacy-15 mask when fifo_en_i is high and compat_i is low. Otherwise entries 6 and 7 use the global mask.
- R5: Buffer 14 uses the legacy-14 mask and buffer 15 the legacy-15 mask. Buffers 0 to 13 use the global mask.
- R6: While compat_i is high, neither legacy mask affects any result, and every entry and buffer is judged with the global mask.
- R7: For FIFO entries, mask bits 29 and 30 decide whether IDE and RTR are compared. For buffers, only mask bits 28..0 matter, and RTR is never compared.
- R8: For a frame with IDE=0, only identifier bits 28..18 take part in the comparison. Bits 17..0 of the frame and of the entry have no effect.
- R9: A buffer whose IDE differs from the frame's IDE never hits, whatever the mask. A buffer with mb_rx_en_i low never hits.
- R10: hit_valid_o is high exactly in the cycle after rx_valid_i was sampled high. The hit outputs change only at such edges and otherwise hold. fifo_hit_o is zero for a strobe taken while fifo_en_i is low.
- R11: fifo_any_o is high when any bit of fifo_hit_o is set. fifo_win_o is the lowest set index, or 0 when none is set.
- R12: A frame strobed in the same cycle as an accepted mask write is judged with the mask value held before that write.
- R13: reg_rdata_o shows, one cycle after reg_addr_i is applied, the global mask (address 0), the legacy-14 mask (1), the legacy-15 mask (2), or zero (3). A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| freeze_i | input | 1 | Allows mask writes while high |
| reg_wr_i | input | 1 | Mask write request |
| reg_addr_i | input | 2 | Mask select for read and write |
| reg_wdata_i | input | 32 | Mask write data |
| reg_rdata_o | output | 32 | Registered mask read data |
| fifo_en_i | input | 1 | FIFO filter table in use |
| compat_i | input | 1 | Retires both legacy masks |
| flt_id_i | input | N_FIFO*29 | Filter table identifiers, entry e at bits e*29 upward |
| flt_ide_i | input | N_FIFO | Filter table IDE bits |
| flt_rtr_i | input | N_FIFO | Filter table RTR bits |
| mb_id_i | input | N_MB*29 | Buffer identifiers, buffer b at bits b*29 upward |
| mb_ide_i | input | N_MB | Buffer IDE bits |
| mb_rx_en_i | input | N_MB | Buffer is an active receive buffer |
| rx_valid_i | input | 1 | Received frame strobe |
| rx_id_i | input | 29 | Received identifier |
| rx_ide_i | input | 1 | Received IDE bit |
| rx_rtr_i | input | 1 | Received RTR bit |
| hit_valid_o | output | 1 | Hit outputs refreshed this cycle |
| fifo_hit_o | output | N_FIFO | FIFO entry hit vector |
| fifo_any_o | output | 1 | Some FIFO entry hit |
| fifo_win_o | output | $clog2(N_FIFO) | Lowest hitting FIFO entry |
| mb_hit_o | output | N_MB | Buffer hit vector |

## Verification
A mask write and a frame comparison can land on the same clock edge. The comparison must then use the mask from before that edge, while the register takes the new value for later frames. The bench provokes this by raising reg_wr_i with freeze_i and rx_valid_i in one cycle, so that the global mask goes from a selective pattern to all zeros. It expects the first result to match the old pattern (two FIFO entries plus the legacy-selected ones). It then sends the same frame again and expects every ID-agnostic entry and IDE-consistent buffer to hit. The vector table covers mask selection across the FIFO, normal and compatibility modes, and directed steps cover reset, locked writes and read-back.

// File: rtl/can_flt_pkg.sv
`timescale 1ns/1ps
package can_flt_pkg;
  localparam int ID_W   = 29;
  localparam int KEY_W  = 32;
  localparam int STD_LO = 18;

  // register addresses, also the order of masks inside the bank
  localparam logic [1:0] ADDR_GLOBAL = 2'd0;
  localparam logic [1:0] ADDR_LEG14  = 2'd1;
  localparam logic [1:0] ADDR_LEG15  = 2'd2;

  // compared fields: identifier only, and standard-frame identifier part
  localparam logic [KEY_W-1:0] ID_FIELD = (KEY_W'(1) << ID_W) - KEY_W'(1);
  localparam logic [KEY_W-1:0] STD_KEEP = ~((KEY_W'(1) << STD_LO) - KEY_W'(1));

  typedef struct packed {
    logic            pad;
    logic            rtr;
    logic            ide;
    logic [ID_W-1:0] id;
  } key_t;
endpackage

// File: rtl/can_mask_bank.sv
`timescale 1ns/1ps
module can_mask_bank #(
  parameter int MASK_W = 32,
  parameter int N_MASK = 3,
  parameter int AW     = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     freeze_i,
  input  logic                     wr_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [MASK_W-1:0]        wdata_i,
  output logic [MASK_W-1:0]        rdata_o,
  output logic [N_MASK*MASK_W-1:0] masks_o
);
  logic [MASK_W-1:0] bank [N_MASK];
  logic              addr_ok;

  assign addr_ok = (int'(addr_i) < N_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N_MASK; k++) bank[k] <= '1;
      rdata_o <= '0;
    end else begin
      if (wr_i && freeze_i && addr_ok) bank[addr_i] <= wdata_i;
      rdata_o <= addr_ok ? bank[addr_i] : '0;
    end
  end

  for (genvar m = 0; m < N_MASK; m++) begin : g_out
    assign masks_o[m*MASK_W +: MASK_W] = bank[m];
  end
endmodule

// File: rtl/can_mask_select.sv
`timescale 1ns/1ps
module can_mask_select #(
  parameter int MASK_W    = 32,
  parameter int N_ELEM    = 8,
  parameter int LEG_A_IDX = 6,
  parameter int LEG_B_IDX = 7
) (
  input  logic                     legacy_on_i,
  input  logic [MASK_W-1:0]        mask_g_i,
  input  logic [MASK_W-1:0]        mask_a_i,
  input  logic [MASK_W-1:0]        mask_b_i,
  output logic [N_ELEM*MASK_W-1:0] mask_o
);
  for (genvar e = 0; e < N_ELEM; e++) begin : g_elem
    if (e == LEG_A_IDX) begin : g_leg_a
      assign mask_o[e*MASK_W +: MASK_W] = legacy_on_i ? mask_a_i : mask_g_i;
    end else if (e == LEG_B_IDX) begin : g_leg_b
      assign mask_o[e*MASK_W +: MASK_W] = legacy_on_i ? mask_b_i : mask_g_i;
    end else begin : g_glob
      assign mask_o[e*MASK_W +: MASK_W] = mask_g_i;
    end
  end
endmodule

// File: rtl/can_id_compare.sv
`timescale 1ns/1ps
module can_id_compare
  import can_flt_pkg::*;
#(
  parameter bit FIFO_STYLE = 1'b1
) (
  input  key_t             rx_i,
  input  key_t             flt_i,
  input  logic [KEY_W-1:0] mask_i,
  output logic             hit_o
);
  logic [KEY_W-1:0] keep;
  logic [KEY_W-1:0] care;
  logic [KEY_W-1:0] diff;

  // standard frames compare only the upper identifier positions
  assign keep = rx_i.ide ? '1 : STD_KEEP;
  assign diff = rx_i ^ flt_i;

  if (FIFO_STYLE) begin : g_fifo
    assign care  = mask_i & keep;
    assign hit_o = ((diff & care) == '0);
  end else begin : g_buf
    assign care  = mask_i & keep & ID_FIELD;
    assign hit_o = ((diff & care) == '0) && (rx_i.ide == flt_i.ide);
  end
endmodule

// File: rtl/can_mask_filter.sv
`timescale 1ns/1ps
module can_mask_filter
  import can_flt_pkg::*;
#(
  parameter int N_FIFO     = 8,
  parameter int N_MB       = 16,
  parameter int FIFO_LEG_A = 6,
  parameter int FIFO_LEG_B = 7,
  parameter int MB_LEG_A   = 14,
  parameter int MB_LEG_B   = 15,
  parameter int WIN_W      = $clog2(N_FIFO)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   freeze_i,
  input  logic                   reg_wr_i,
  input  logic [1:0]             reg_addr_i,
  input  logic [KEY_W-1:0]       reg_wdata_i,
  output logic [KEY_W-1:0]       reg_rdata_o,
  input  logic                   fifo_en_i,
  input  logic                   compat_i,
  input  logic [N_FIFO*ID_W-1:0] flt_id_i,
  input  logic [N_FIFO-1:0]      flt_ide_i,
  input  logic [N_FIFO-1:0]      flt_rtr_i,
  input  logic [N_MB*ID_W-1:0]   mb_id_i,
  input  logic [N_MB-1:0]        mb_ide_i,
  input  logic [N_MB-1:0]        mb_rx_en_i,
  input  logic                   rx_valid_i,
  input  logic [ID_W-1:0]        rx_id_i,
  input  logic                   rx_ide_i,
  input  logic                   rx_rtr_i,
  output logic                   hit_valid_o,
  output logic [N_FIFO-1:0]      fifo_hit_o,
  output logic                   fifo_any_o,
  output logic [WIN_W-1:0]       fifo_win_o,
  output logic [N_MB-1:0]        mb_hit_o
);
  localparam int N_MASK = 3;

  logic [N_MASK*KEY_W-1:0] masks;
  logic [KEY_W-1:0]        mask_g, mask_a, mask_b;
  logic [N_FIFO*KEY_W-1:0] fifo_masks;
  logic [N_MB*KEY_W-1:0]   mb_masks;
  logic [N_FIFO-1:0]       fifo_hit_c;
  logic [N_MB-1:0]         mb_raw_c;
  logic [N_MB-1:0]         mb_hit_c;
  logic [WIN_W-1:0]        win_c;
  logic                    fifo_leg_on;
  logic                    mb_leg_on;
  key_t                    rx_key;

  can_mask_bank #(.MASK_W(KEY_W), .N_MASK(N_MASK), .AW(2)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .freeze_i (freeze_i),
    .wr_i     (reg_wr_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .masks_o  (masks)
  );

  assign mask_g = masks[int'(ADDR_GLOBAL)*KEY_W +: KEY_W];
  assign mask_a = masks[int'(ADDR_LEG14)*KEY_W +: KEY_W];
  assign mask_b = masks[int'(ADDR_LEG15)*KEY_W +: KEY_W];

  assign fifo_leg_on = fifo_en_i && !compat_i;
  assign mb_leg_on   = !compat_i;

  can_mask_select #(.MASK_W(KEY_W), .N_ELEM(N_FIFO),
                    .LEG_A_IDX(FIFO_LEG_A), .LEG_B_IDX(FIFO_LEG_B)) u_sel_fifo (
    .legacy_on_i (fifo_leg_on),
    .mask_g_i    (mask_g),
    .mask_a_i    (mask_a),
    .mask_b_i    (mask_b),
    .mask_o      (fifo_masks)
  );

  can_mask_select #(.MASK_W(KEY_W), .N_ELEM(N_MB),
                    .LEG_A_IDX(MB_LEG_A), .LEG_B_IDX(MB_LEG_B)) u_sel_mb (
    .legacy_on_i (mb_leg_on),
    .mask_g_i    (mask_g),
    .mask_a_i    (mask_a),
    .mask_b_i    (mask_b),
    .mask_o      (mb_masks)
  );

  assign rx_key = key_t'({1'b0, rx_rtr_i, rx_ide_i, rx_id_i});

  for (genvar e = 0; e < N_FIFO; e++) begin : g_fifo_cmp
    key_t flt_key;
    assign flt_key = key_t'({1'b0, flt_rtr_i[e], flt_ide_i[e], flt_id_i[e*ID_W +: ID_W]});
    can_id_compare #(.FIFO_STYLE(1'b1)) u_cmp (
      .rx_i   (rx_key),
      .flt_i  (flt_key),
      .mask_i (fifo_masks[e*KEY_W +: KEY_W]),
      .hit_o  (fifo_hit_c[e])
    );
  end

  for (genvar b = 0; b < N_MB; b++) begin : g_mb_cmp
    key_t buf_key;
    assign buf_key = key_t'({1'b0, 1'b0, mb_ide_i[b], mb_id_i[b*ID_W +: ID_W]});
    can_id_compare #(.FIFO_STYLE(1'b0)) u_cmp (
      .rx_i   (rx_key),
      .flt_i  (buf_key),
      .mask_i (mb_masks[b*KEY_W +: KEY_W]),
      .hit_o  (mb_raw_c[b])
    );
  end

  assign mb_hit_c = mb_raw_c & mb_rx_en_i;

  // lowest index wins: scan from the top so the last assignment is the lowest
  always_comb begin
    win_c = '0;
    for (int i = N_FIFO - 1; i >= 0; i--) begin
      if (fifo_hit_c[i]) win_c = WIN_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_valid_o <= 1'b0;
      fifo_hit_o  <= '0;
      fifo_any_o  <= 1'b0;
      fifo_win_o  <= '0;
      mb_hit_o    <= '0;
    end else begin
      hit_valid_o <= rx_valid_i;
      if (rx_valid_i) begin
        fifo_hit_o <= fifo_en_i ? fifo_hit_c : '0;
        fifo_any_o <= fifo_en_i && (fifo_hit_c != '0);
        fifo_win_o <= fifo_en_i ? win_c : '0;
        mb_hit_o   <= mb_hit_c;
      end
    end
  end
endmodule

// File: rtl/can_mask_filter_chk.sv
`timescale 1ns/1ps
module can_mask_filter_chk #(
  parameter int N_FIFO = 8,
  parameter int N_MB   = 16,
  parameter int WIN_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              freeze_i,
  input logic              reg_wr_i,
  input logic [1:0]        reg_addr_i,
  input logic [31:0]       reg_wdata_i,
  input logic              fifo_en_i,
  input logic              rx_valid_i,
  input logic              rx_ide_i,
  input logic [N_MB-1:0]   mb_ide_i,
  input logic [N_MB-1:0]   mb_rx_en_i,
  input logic              hit_valid_o,
  input logic [N_FIFO-1:0] fifo_hit_o,
  input logic              fifo_any_o,
  input logic [WIN_W-1:0]  fifo_win_o,
  input logic [N_MB-1:0]   mb_hit_o,
  input logic [31:0]       mask_g,
  input logic [31:0]       mask_a,
  input logic [31:0]       mask_b
);
  logic [N_FIFO-1:0] below_win;
  assign below_win = (N_FIFO'(1) << fifo_win_o) - N_FIFO'(1);

  p_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    rx_valid_i |=> hit_valid_o);

  p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !rx_valid_i |=> !hit_valid_o);

  p_fifo_off_r10: assert property (@(posedge clk) disable iff (rst)
    (rx_valid_i && !fifo_en_i) |=> (fifo_hit_o == '0));

  p_locked_r3: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr_i && freeze_i) |=> ($stable(mask_g) && $stable(mask_a) && $stable(mask_b)));

  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_i && freeze_i && reg_addr_i == 2'd0) |=> (mask_g == $past(reg_wdata_i)));

  p_any_r11: assert property (@(posedge clk) disable iff (rst)
    fifo_any_o == (fifo_hit_o != '0));

  p_win_r11: assert property (@(posedge clk) disable iff (rst)
    fifo_any_o |-> (fifo_hit_o[fifo_win_o] && ((fifo_hit_o & below_win) == '0)));

  for (genvar b = 0; b < N_MB; b++) begin : g_buf_chk
    p_mb_ide_r9: assert property (@(posedge clk) disable iff (rst)
      (hit_valid_o && mb_hit_o[b]) |-> ($past(rx_ide_i) == $past(mb_ide_i[b])));
    p_mb_en_r9: assert property (@(posedge clk) disable iff (rst)
      (hit_valid_o && mb_hit_o[b]) |-> $past(mb_rx_en_i[b]));
  end
endmodule

bind can_mask_filter can_mask_filter_chk #(.N_FIFO(N_FIFO), .N_MB(N_MB), .WIN_W(WIN_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .freeze_i    (freeze_i),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .fifo_en_i   (fifo_en_i),
  .rx_valid_i  (rx_valid_i),
  .rx_ide_i    (rx_ide_i),
  .mb_ide_i    (mb_ide_i),
  .mb_rx_en_i  (mb_rx_en_i),
  .hit_valid_o (hit_valid_o),
  .fifo_hit_o  (fifo_hit_o),
  .fifo_any_o  (fifo_any_o),
  .fifo_win_o  (fifo_win_o),
  .mb_hit_o    (mb_hit_o),
  .mask_g      (mask_g),
  .mask_a      (mask_a),
  .mask_b      (mask_b)
);

// File: tb/can_mask_filter_test.sv
`timescale 1ns/1ps
module can_mask_filter_test;
  localparam int NF = 8;
  localparam int NB = 16;
  localparam int IW = 29;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            freeze = 1'b0;
  logic            wr = 1'b0;
  logic [1:0]      addr = 2'd0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic            fifo_en = 1'b0;
  logic            compat = 1'b0;
  logic [NF*IW-1:0] flt_id = '0;
  logic [NF-1:0]   flt_ide = '0;
  logic [NF-1:0]   flt_rtr = '0;
  logic [NB*IW-1:0] mb_id = '0;
  logic [NB-1:0]   mb_ide = '0;
  logic [NB-1:0]   mb_en = '0;
  logic            rx_valid = 1'b0;
  logic [IW-1:0]   rx_id = '0;
  logic            rx_ide = 1'b0;
  logic            rx_rtr = 1'b0;
  logic            hit_valid;
  logic [NF-1:0]   fifo_hit;
  logic            fifo_any;
  logic [2:0]      fifo_win;
  logic [NB-1:0]   mb_hit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  can_mask_filter uut (
    .clk(clk), .rst(rst), .freeze_i(freeze), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .fifo_en_i(fifo_en), .compat_i(compat),
    .flt_id_i(flt_id), .flt_ide_i(flt_ide), .flt_rtr_i(flt_rtr),
    .mb_id_i(mb_id), .mb_ide_i(mb_ide), .mb_rx_en_i(mb_en),
    .rx_valid_i(rx_valid), .rx_id_i(rx_id), .rx_ide_i(rx_ide), .rx_rtr_i(rx_rtr),
    .hit_valid_o(hit_valid), .fifo_hit_o(fifo_hit), .fifo_any_o(fifo_any),
    .fifo_win_o(fifo_win), .mb_hit_o(mb_hit)
  );

  typedef struct packed {
    logic [28:0] id;
    logic        ide;
    logic        rtr;
    logic        fen;
    logic        cmp;
    logic [7:0]  efifo;
    logic [2:0]  ewin;
    logic [15:0] emb;
  } vec_t;

  // masks in force: global 7FFFFF00, legacy-14 1FFF0000, legacy-15 00000000
  localparam vec_t [0:7] VECS = '{
    '{29'h0ABCDE12, 1'b1, 1'b0, 1'b1, 1'b0, 8'hC3, 3'd0, 16'h4001}, // R2 R4 R5: entries 0,1 + legacy 6,7
    '{29'h0ABCDE12, 1'b1, 1'b0, 1'b1, 1'b1, 8'h03, 3'd0, 16'h0001}, // R6 compat
    '{29'h0ABCDE12, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0, 16'h4001}, // R10 fifo off
    '{29'h048C0000, 1'b0, 1'b0, 1'b1, 1'b0, 8'h90, 3'd4, 16'h8004}, // R8 standard
    '{29'h048C0000, 1'b0, 1'b1, 1'b1, 1'b0, 8'h80, 3'd7, 16'h8004}, // R7 RTR fifo only
    '{29'h01234599, 1'b1, 1'b1, 1'b1, 1'b0, 8'h84, 3'd2, 16'h0000}, // R7 RTR match
    '{29'h01234599, 1'b1, 1'b0, 1'b1, 1'b0, 8'h80, 3'd7, 16'h0000}, // R7 RTR mismatch
    '{29'h0003FFFF, 1'b0, 1'b0, 1'b1, 1'b1, 8'h20, 3'd5, 16'h8000}  // R8 low bits ignored, R6
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_mask(input logic [1:0] a, input logic [31:0] d, input logic frz);
    @(negedge clk);
    freeze = frz; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; freeze = 1'b0;
  endtask

  task automatic read_mask(input logic [1:0] a, input string tag, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    check(tag, rdata, exp);
  endtask

  task automatic send(input logic [28:0] id, input logic ide, input logic rtr,
                      input logic fen, input logic cmp);
    @(negedge clk);
    rx_id = id; rx_ide = ide; rx_rtr = rtr; fifo_en = fen; compat = cmp; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic set_flt(input int e, input logic [28:0] id, input logic ide, input logic rtr);
    flt_id[e*IW +: IW] = id; flt_ide[e] = ide; flt_rtr[e] = rtr;
  endtask

  task automatic set_mb(input int b, input logic [28:0] id, input logic ide, input logic en);
    mb_id[b*IW +: IW] = id; mb_ide[b] = ide; mb_en[b] = en;
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R10: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    set_flt(0, 29'h0ABCDE00, 1'b1, 1'b0);
    set_flt(1, 29'h0ABCDE55, 1'b1, 1'b0);
    set_flt(2, 29'h01234500, 1'b1, 1'b1);
    set_flt(3, 29'h0ABCDF00, 1'b1, 1'b0);
    set_flt(4, 29'h048C0000, 1'b0, 1'b0);
    set_flt(5, 29'h00000000, 1'b0, 1'b0);
    set_flt(6, 29'h0ABC0000, 1'b0, 1'b1);
    set_flt(7, 29'h1FFFFFFF, 1'b0, 1'b0);
    for (int b = 0; b < NB; b++) set_mb(b, 29'h1FFFFFFF, 1'b1, 1'b1);
    set_mb(0, 29'h0ABCDE00, 1'b1, 1'b1);
    set_mb(1, 29'h0ABCDE00, 1'b0, 1'b1);
    set_mb(2, 29'h048C0000, 1'b0, 1'b1);
    set_mb(13, 29'h0ABCDE00, 1'b1, 1'b0);
    set_mb(14, 29'h0ABC1234, 1'b1, 1'b1);
    set_mb(15, 29'h00000007, 1'b0, 1'b1);

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 hit_valid", {31'b0, hit_valid}, 32'h0);
    check("R1 fifo_hit", {24'b0, fifo_hit}, 32'h0);
    check("R1 mb_hit", {16'b0, mb_hit}, 32'h0);
    check("R1 fifo_any/win", {28'b0, fifo_any, fifo_win}, 32'h0);
    read_mask(2'd0, "R1 global mask", 32'hFFFF_FFFF);
    read_mask(2'd1, "R1 legacy14 mask", 32'hFFFF_FFFF);
    read_mask(2'd2, "R1 legacy15 mask", 32'hFFFF_FFFF);

    // R3 write without freeze ignored
    write_mask(2'd0, 32'h0000_0000, 1'b0);
    read_mask(2'd0, "R3 unfrozen write", 32'hFFFF_FFFF);

    // R3 R13 load masks in freeze, read back, address 3
    write_mask(2'd0, 32'h7FFF_FF00, 1'b1);
    write_mask(2'd1, 32'h1FFF_0000, 1'b1);
    write_mask(2'd2, 32'h0000_0000, 1'b1);
    write_mask(2'd3, 32'h1234_5678, 1'b1);
    read_mask(2'd0, "R3 R13 global", 32'h7FFF_FF00);
    read_mask(2'd1, "R13 legacy14", 32'h1FFF_0000);
    read_mask(2'd2, "R13 legacy15", 32'h0000_0000);
    read_mask(2'd3, "R13 addr3", 32'h0000_0000);

    // vector table: R2 R4 R5 R6 R7 R8 R9 R11
    for (int v = 0; v < 8; v++) begin
      send(VECS[v].id, VECS[v].ide, VECS[v].rtr, VECS[v].fen, VECS[v].cmp);
      check($sformatf("R10 valid v%0d", v), {31'b0, hit_valid}, 32'h1);
      check($sformatf("R2 R4 R6 R7 R8 fifo v%0d", v), {24'b0, fifo_hit}, {24'b0, VECS[v].efifo});
      check($sformatf("R5 R6 R9 mb v%0d", v), {16'b0, mb_hit}, {16'b0, VECS[v].emb});
      check($sformatf("R11 win v%0d", v), {28'b0, fifo_any, fifo_win},
            {28'b0, (VECS[v].efifo != 8'h0), VECS[v].ewin});
    end

    // R10 pulse ends and outputs hold
    @(negedge clk);
    check("R10 valid drops", {31'b0, hit_valid}, 32'h0);
    check("R10 hold fifo", {24'b0, fifo_hit}, 32'h20);
    check("R10 hold mb", {16'b0, mb_hit}, 32'h8000);

    // R12 same-cycle write of global mask and frame
    @(negedge clk);
    freeze = 1'b1; wr = 1'b1; addr = 2'd0; wdata = 32'h0;
    rx_id = 29'h0ABCDE12; rx_ide = 1'b1; rx_rtr = 1'b0; fifo_en = 1'b1; compat = 1'b0;
    rx_valid = 1'b1;
    @(negedge clk);
    wr = 1'b0; freeze = 1'b0; rx_valid = 1'b0;
    check("R12 old mask fifo", {24'b0, fifo_hit}, 32'hC3);
    check("R12 old mask mb", {16'b0, mb_hit}, 32'h4001);
    send(29'h0ABCDE12, 1'b1, 1'b0, 1'b1, 1'b0);
    check("R12 new mask fifo", {24'b0, fifo_hit}, 32'hFF);
    check("R9 R12 new mask mb", {16'b0, mb_hit}, 32'h5FF9);
    check("R11 win all", {28'b0, fifo_any, fifo_win}, 32'h8);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule